// File: doc/BRIEF.md
# Mixed-width transmit buffer write port

This block is the processor-facing write side of a 32-byte transmit FIFO whose output feeds a serializer one byte at a time. Software stores data through two byte addresses, one for the high byte and one for the low byte. A single store is either a 16-bit word, which pushes two bytes, or one byte written to either address, which pushes one byte. A two-bit mode input decides which half of a word enters the queue first. In one mode the port accepts only byte stores.

Software polls a ready flag before it writes. The flag compares the number of bytes held against a programmable 5-bit threshold. A store that does not fit is dropped whole and sets a sticky overflow flag, and the bytes already queued are not touched. The serializer drains the queue through a valid/ready byte handshake.

Top module: `txbuf_wrport`

## Requirements
- R1: After reset the buffer is empty, `pop_valid` is 0, `tx_rdy` is 1 and `ovf` is 0.
- R2: A byte store (`wr_en`=1, `wr_word`=0) appends one entry. That entry is `wr_data[15:8]` when `wr_hi`=1 and `wr_data[7:0]` when `wr_hi`=0. Byte stores are accepted in every mode.
- R3: In mode 0 (`cpu_mode`=00), a word store queues `wr_data[7:0]` first and then `wr_data[15:8]`.
- R4: In modes 2 and 3 (`cpu_mode`=10 or 11), a word store queues `wr_data[15:8]` first and then `wr_data[7:0]`.
- R5: In mode 1 (`cpu_mode`=01), a word store is discarded and sets `ovf`. The queue is left unchanged.
- R6: A word store is accepted only if at least two slots are free, that is, the count is 30 or less before the edge. Otherwise it is discarded whole and sets `ovf`.
- R7: A byte store while all 32 slots are full is discarded and sets `ovf`. The stored bytes stay intact. Free space is judged on the count before any pop in the same cycle.
- R8: Bytes leave in the order they were inserted. `pop_valid` is 1 exactly while the buffer is not empty. A byte is removed on a clock edge where `pop_valid` and `pop_ready` are both 1. `pop_data` holds steady while the consumer stalls.
- R9: `tx_rdy` is registered. After each edge it equals (count of stored bytes ≤ `ready_thresh`).
- R10: `ovf` stays set until `ovf_clr` is asserted. A store rejected in the same cycle as `ovf_clr` leaves `ovf` set.
- R11: A push of one or two bytes and a pop in the same cycle are both carried out, and the count changes by their net amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store strobe |
| wr_word | input | 1 | 1 = 16-bit store, 0 = byte store |
| wr_hi | input | 1 | Byte store target: 1 = high-byte address, 0 = low-byte address |
| wr_data | input | 16 | Store data |
| cpu_mode | input | 2 | Ordering and width mode |
| ready_thresh | input | 5 | Ready threshold in bytes |
| ovf_clr | input | 1 | Clears the overflow flag |
| tx_rdy | output | 1 | Count is at or below the threshold |
| ovf | output | 1 | Sticky flag for a dropped store |
| pop_valid | output | 1 | Buffer holds a byte |
| pop_ready | input | 1 | Serializer takes the byte |
| pop_data | output | 8 | Oldest stored byte |

## Verification
On every cycle, the assertions check four things: the fill bound, that a word store which is refused (for lack of room or in byte-only mode) raises `ovf`, that `ovf` is sticky, and that the head byte holds while the consumer stalls. They also check that `tx_rdy` agrees with the count. Only the bench scenarios can show the byte order of each mode, the survival of queued contents after a refused store, and the exact boundary at 30 and 31 bytes. The same holds for the net count change when a push and a pop share a cycle, since these need the data to be read back out through the pop port.

// File: rtl/txbuf_wrport.sv
module txbuf_wrport #(
  parameter int DEPTH = 32,
  parameter int TW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_word,
  input  logic          wr_hi,
  input  logic [15:0]   wr_data,
  input  logic [1:0]    cpu_mode,
  input  logic [TW-1:0] ready_thresh,
  input  logic          ovf_clr,
  output logic          tx_rdy,
  output logic          ovf,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [7:0]    pop_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nxt, free;

  assign free = CW'(DEPTH) - cnt;

  wire word_ok = (free >= CW'(2)) && (cpu_mode != 2'b01);
  wire byte_ok = (free != '0);
  wire push2   = wr_en & wr_word & word_ok;
  wire push1   = wr_en & ~wr_word & byte_ok;
  wire reject  = wr_en & ~(push1 | push2);
  wire pop     = pop_valid & pop_ready;

  wire [7:0] hi_b = wr_data[15:8];
  wire [7:0] lo_b = wr_data[7:0];
  wire [7:0] b0 = wr_word ? (cpu_mode[1] ? hi_b : lo_b) : (wr_hi ? hi_b : lo_b);
  wire [7:0] b1 = cpu_mode[1] ? lo_b : hi_b;

  assign cnt_nxt   = cnt + (push2 ? CW'(2) : push1 ? CW'(1) : CW'(0)) - CW'(pop);
  assign pop_valid = (cnt != '0);
  assign pop_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push1 | push2) mem[wptr] <= b0;
    if (push2)         mem[wptr + AW'(1)] <= b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      tx_rdy <= 1'b1;
      ovf    <= 1'b0;
    end else begin
      wptr   <= wptr + (push2 ? AW'(2) : push1 ? AW'(1) : AW'(0));
      rptr   <= rptr + AW'(pop);
      cnt    <= cnt_nxt;
      tx_rdy <= (cnt_nxt <= CW'(ready_thresh));
      if (reject)       ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R6
  word_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word && cnt > CW'(DEPTH - 2)) |=> ovf);

  // R5
  mode1_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word && cpu_mode == 2'b01) |=> (ovf && cnt <= $past(cnt)));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data)));

  // R9
  rdy_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (tx_rdy == (cnt <= CW'($past(ready_thresh)))));
endmodule

// File: tb/txbuf_wrport_tb.sv
module txbuf_wrport_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_word = 0, wr_hi = 0, ovf_clr = 0, pop_ready = 0;
  logic [15:0] wr_data = '0;
  logic [1:0]  cpu_mode = '0;
  logic [4:0]  ready_thresh = 5'd4;
  logic tx_rdy, ovf, pop_valid;
  logic [7:0] pop_data;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  txbuf_wrport u_dut (.clk, .rst_n, .wr_en, .wr_word, .wr_hi, .wr_data, .cpu_mode,
    .ready_thresh, .ovf_clr, .tx_rdy, .ovf, .pop_valid, .pop_ready, .pop_data);

  // {mode[2], word, hi, data[16], e0[8], e1[8], n[2]}
  localparam logic [37:0] VEC [9] = '{
    {2'd0, 1'b0, 1'b0, 16'h1234, 8'h34, 8'h00, 2'd1},
    {2'd0, 1'b0, 1'b1, 16'h1234, 8'h12, 8'h00, 2'd1},
    {2'd0, 1'b1, 1'b0, 16'hABCD, 8'hCD, 8'hAB, 2'd2},
    {2'd2, 1'b1, 1'b0, 16'hABCD, 8'hAB, 8'hCD, 2'd2},
    {2'd3, 1'b1, 1'b1, 16'h5A3C, 8'h5A, 8'h3C, 2'd2},
    {2'd1, 1'b0, 1'b1, 16'h77EE, 8'h77, 8'h00, 2'd1},
    {2'd1, 1'b0, 1'b0, 16'h77EE, 8'hEE, 8'h00, 2'd1},
    {2'd1, 1'b1, 1'b0, 16'h1111, 8'h00, 8'h00, 2'd0},
    {2'd3, 1'b0, 1'b0, 16'h0F80, 8'h80, 8'h00, 2'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic store(input logic [1:0] m, input logic w, input logic h, input logic [15:0] d);
    @(negedge clk);
    cpu_mode = m; wr_word = w; wr_hi = h; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic take(input logic [7:0] exp, input string tag);
    chk(pop_valid === 1'b1, {tag, " valid"}, int'(pop_valid), 1);
    chk(pop_data === exp, tag, int'(pop_data), int'(exp));
    pop_ready = 1;
    @(negedge clk);
    pop_ready = 0;
  endtask

  task automatic clear_ovf();
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(pop_valid === 1'b0, "R1 pop_valid", int'(pop_valid), 0);
    chk(tx_rdy === 1'b1, "R1 tx_rdy", int'(tx_rdy), 1);
    chk(ovf === 1'b0, "R1 ovf", int'(ovf), 0);
    rst_n = 1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5
    foreach (VEC[i]) begin
      logic [37:0] v;
      v = VEC[i];
      store(v[37:36], v[35], v[34], v[33:18]);
      if (v[1:0] == 2'd0) begin
        chk(ovf === 1'b1, "R5 ovf", int'(ovf), 1);
        chk(pop_valid === 1'b0, "R5 unchanged", int'(pop_valid), 0);
        clear_ovf();
      end else begin
        take(v[17:10], "R2/R3/R4 first byte");
        if (v[1:0] == 2'd2) take(v[9:2], "R3/R4 second byte");
        chk(pop_valid === 1'b0, "R8 drained", int'(pop_valid), 0);
      end
    end

    // R9 threshold, then R6 / R7 boundaries
    ready_thresh = 5'd4;
    for (int k = 0; k < 31; k++) begin
      store(2'd0, 1'b0, 1'b0, 16'(k));
      if (k == 3) chk(tx_rdy === 1'b1, "R9 at thresh", int'(tx_rdy), 1);
      if (k == 4) chk(tx_rdy === 1'b0, "R9 above thresh", int'(tx_rdy), 0);
    end
    store(2'd0, 1'b1, 1'b0, 16'hB1A0);
    chk(ovf === 1'b1, "R6 word at 31", int'(ovf), 1);
    clear_ovf();
    chk(ovf === 1'b0, "R10 cleared", int'(ovf), 0);
    take(8'h00, "R8 head");
    store(2'd0, 1'b1, 1'b0, 16'hB1A0);
    chk(ovf === 1'b0, "R6 word at 30 accepted", int'(ovf), 0);
    store(2'd0, 1'b0, 1'b1, 16'hEE00);
    chk(ovf === 1'b1, "R7 byte when full", int'(ovf), 1);
    // R10 reject together with clear keeps ovf
    @(negedge clk);
    ovf_clr = 1; wr_en = 1; wr_word = 0; wr_hi = 0; wr_data = 16'h00EE;
    @(negedge clk);
    ovf_clr = 0; wr_en = 0;
    chk(ovf === 1'b1, "R10 reject wins", int'(ovf), 1);
    clear_ovf();
    for (int k = 1; k < 31; k++) take(8'(k), "R7/R8 order");
    take(8'hA0, "R6 word first");
    take(8'hB1, "R6 word second");
    chk(pop_valid === 1'b0, "R8 empty", int'(pop_valid), 0);
    chk(tx_rdy === 1'b1, "R9 empty ready", int'(tx_rdy), 1);

    // R11 push and pop in one cycle
    store(2'd0, 1'b0, 1'b0, 16'h0055);
    @(negedge clk);
    cpu_mode = 2'd0; wr_word = 1; wr_data = 16'hC2C1; wr_en = 1; pop_ready = 1;
    @(negedge clk);
    wr_en = 0; pop_ready = 0;
    take(8'hC1, "R11 after pop");
    take(8'hC2, "R11 second");
    chk(pop_valid === 1'b0, "R11 net count", int'(pop_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule